// File: doc/BRIEF.md
# Wakeup Pattern Frame Matcher

This block watches a received byte stream and decides, at the last byte of each frame, whether the frame matches one of a bank of programmed wakeup patterns. Each pattern slot holds a byte mask that picks which frame bytes take part, a reference CRC, and a reference value for the last picked byte. A CRC-16 is run over the picked bytes only. When a frame matches, the block raises a one-cycle wake pulse with the number of the matching slot.

Two pattern shapes share one register bank. In normal mode every slot looks at a 64-byte window that starts at frame offset 12, and compares the low 8 bits of its CRC plus the last picked byte. When the wide-pattern enable is set, slots 2 and 3, 4 and 5, and 6 and 7 each become one wide pattern. It looks at offsets 0 to 127 and compares all 16 CRC bits. Slots 0 and 1 stay normal, so the bank then holds two normal patterns and three wide ones.

Configuration is write-only through a byte-wide port. Slot `s` owns addresses `16*s` to `16*s+15`. Field 0..7 holds mask bytes, field 8 the CRC low byte, field 9 the CRC high byte and field 10 the last-byte reference. Address 0x80 bit 0 is the wide-pattern enable.

Top module: `wkp_matcher`

## Requirements
- R1: In normal mode, mask byte k bit b of a slot selects frame offset 12+8k+b. The CRC is CRC-16 with polynomial 0x8005 and initial value 0xFFFF, processed MSB first, with no final XOR, over the selected bytes in offset order. Its low 8 bits must equal the slot's field 8.
- R2: In normal mode a match also needs the byte at the highest selected offset to equal the slot's field 10.
- R3: With address 0x80 bit 0 set, the first slot of each pair (2,3), (4,5), (6,7) uses its own mask for offsets 0..63 and its partner's mask for offsets 64..127. All 16 CRC bits are compared: the low byte against field 8 and the high byte against field 9 of the first slot. The last-byte field is not checked.
- R4: In wide mode the second slot of each pair never reports a match on its own, and its fields 8..10 have no effect. Slots 0 and 1 keep normal behaviour.
- R5: A frame whose last byte lies below the highest selected offset does not match. A frame that reaches exactly that offset can match.
- R6: A slot whose mask is all zero never matches.
- R7: When several slots match the same frame, the lowest-numbered slot is reported.
- R8: `wake_pulse` is high for the single cycle after the end-of-frame byte of a matching frame. `wake_slot` carries the slot number while the pulse is high and is 0 otherwise.
- R9: After reset, all fields and the enable are zero, and no pulse is produced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | ADDR_W (8) | Register address |
| cfg_wdata | input | 8 | Register write data |
| rx_valid | input | 1 | A frame byte is present |
| rx_sof | input | 1 | Byte is offset 0 of a frame |
| rx_eof | input | 1 | Byte is the last of a frame |
| rx_data | input | 8 | Frame byte |
| wake_pulse | output | 1 | One-cycle match indication |
| wake_slot | output | SLOT_W (3) | Number of the matching slot |

## Verification
Normal patterns are tried with a frame that matches, then the same frame against a wrong CRC and against a wrong last-byte reference, so that each of the two compares is shown to be needed. Frames ending one byte before and exactly at the highest selected offset tell the length rule apart from the CRC rule. Several slots programmed with the same pattern expose the priority order, and clearing a mask shows that the slot is disabled. In wide mode, a pattern with mask bits above offset 63 matches only when both high-byte halves are handled. A corrupted high CRC byte must fail. Garbage in the second slot's fields must change nothing, while slot 0 keeps working in normal mode.

// File: rtl/wkp_pkg.sv
package wkp_pkg;
  localparam int NORM_BASE = 12;
  localparam logic [15:0] CRC_POLY = 16'h8005;
  localparam logic [15:0] CRC_INIT = 16'hFFFF;
  localparam int F_CRC_LO = 8;
  localparam int F_CRC_HI = 9;
  localparam int F_LAST   = 10;
  localparam int LONG_FIRST = 2;

  function automatic logic [15:0] crc16_step(input logic [15:0] c, input logic [7:0] d);
    logic [15:0] r;
    r = c ^ {d, 8'h00};
    for (int i = 0; i < 8; i++) begin
      r = r[15] ? ((r << 1) ^ CRC_POLY) : (r << 1);
    end
    return r;
  endfunction
endpackage

// File: rtl/wkp_regs.sv
module wkp_regs #(
  parameter int NUM_SLOTS  = 8,
  parameter int MASK_BYTES = 8,
  parameter int ADDR_W     = 8,
  localparam int WIN = MASK_BYTES * 8
) (
  input  logic clk,
  input  logic rst,
  input  logic cfg_we,
  input  logic [ADDR_W-1:0] cfg_addr,
  input  logic [7:0] cfg_wdata,
  output logic [NUM_SLOTS-1:0][WIN-1:0] mask_o,
  output logic [NUM_SLOTS-1:0][15:0] crc_o,
  output logic [NUM_SLOTS-1:0][7:0] last_o,
  output logic long_en
);
  import wkp_pkg::*;
  localparam int SEL_W = ADDR_W - 5;

  logic [NUM_SLOTS-1:0][MASK_BYTES-1:0][7:0] mask_q;
  logic [NUM_SLOTS-1:0][15:0] crc_q;
  logic [NUM_SLOTS-1:0][7:0] last_q;
  logic long_q;

  logic is_ctrl;
  logic [SEL_W-1:0] sel;
  logic [3:0] fld;
  assign is_ctrl = cfg_addr[ADDR_W-1];
  assign sel = cfg_addr[ADDR_W-2:4];
  assign fld = cfg_addr[3:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      mask_q <= '0;
      crc_q  <= '0;
      last_q <= '0;
      long_q <= 1'b0;
    end else if (cfg_we) begin
      if (is_ctrl) begin
        long_q <= cfg_wdata[0];
      end else if (int'(sel) < NUM_SLOTS) begin
        if (int'(fld) < MASK_BYTES) mask_q[sel][fld[$clog2(MASK_BYTES)-1:0]] <= cfg_wdata;
        else if (int'(fld) == F_CRC_LO) crc_q[sel][7:0] <= cfg_wdata;
        else if (int'(fld) == F_CRC_HI) crc_q[sel][15:8] <= cfg_wdata;
        else if (int'(fld) == F_LAST) last_q[sel] <= cfg_wdata;
      end
    end
  end

  always_comb begin
    for (int s = 0; s < NUM_SLOTS; s++) mask_o[s] = mask_q[s];
  end
  assign crc_o = crc_q;
  assign last_o = last_q;
  assign long_en = long_q;

  a_r9_enable_cleared: assert property (@(posedge clk) $past(rst) |-> !long_en);
endmodule

// File: rtl/wkp_slot_engine.sv
module wkp_slot_engine #(
  parameter int WIN   = 64,
  parameter int OFF_W = 8,
  localparam int SPAN = 2 * WIN,
  localparam int IDX_W = $clog2(SPAN)
) (
  input  logic clk,
  input  logic rst,
  input  logic byte_ok,
  input  logic sof,
  input  logic eval,
  input  logic [OFF_W-1:0] offset,
  input  logic [7:0] data,
  input  logic [SPAN-1:0] mask,
  input  logic wide,
  input  logic active,
  input  logic [15:0] ref_crc,
  input  logic [7:0] ref_last,
  output logic hit
);
  import wkp_pkg::*;

  logic [15:0] crc_q, crc_cur, crc_nxt;
  logic [7:0] last_q, last_cur, last_nxt;
  logic reached_q, reached_cur, reached_nxt;
  logic [IDX_W-1:0] hi_idx;
  logic [OFF_W:0] base, widx_full;
  logic [IDX_W-1:0] widx;
  logic in_win, take;

  always_comb begin
    hi_idx = '0;
    for (int i = 0; i < SPAN; i++) begin
      if (mask[i]) hi_idx = IDX_W'(i);
    end
  end

  assign base = wide ? '0 : (OFF_W+1)'(NORM_BASE);
  assign widx_full = {1'b0, offset} - base;
  assign widx = widx_full[IDX_W-1:0];
  assign in_win = ({1'b0, offset} >= base) &&
                  (widx_full < (wide ? (OFF_W+1)'(SPAN) : (OFF_W+1)'(WIN)));
  assign take = in_win && mask[widx];

  assign crc_cur = sof ? CRC_INIT : crc_q;
  assign last_cur = sof ? 8'h00 : last_q;
  assign reached_cur = sof ? 1'b0 : reached_q;
  assign crc_nxt = take ? crc16_step(crc_cur, data) : crc_cur;
  assign last_nxt = take ? data : last_cur;
  assign reached_nxt = reached_cur | (in_win && (widx == hi_idx));

  always_ff @(posedge clk) begin
    if (rst) begin
      crc_q <= CRC_INIT;
      last_q <= 8'h00;
      reached_q <= 1'b0;
    end else if (byte_ok) begin
      crc_q <= crc_nxt;
      last_q <= last_nxt;
      reached_q <= reached_nxt;
    end
  end

  logic crc_ok;
  assign crc_ok = wide ? (crc_nxt == ref_crc)
                       : ((crc_nxt[7:0] == ref_crc[7:0]) && (last_nxt == ref_last));
  assign hit = byte_ok && eval && active && (|mask) && reached_nxt && crc_ok;

  // R5: once the highest selected offset is passed, the frame stays long enough
  a_r5_reached_sticky: assert property (@(posedge clk) disable iff (rst)
    (reached_q && !(byte_ok && sof)) |=> reached_q);
  // R6: an empty mask never yields a hit
  a_r6_empty_mask_silent: assert property (@(posedge clk) disable iff (rst)
    (mask == '0) |-> !hit);
endmodule

// File: rtl/wkp_arbiter.sv
module wkp_arbiter #(
  parameter int NUM_SLOTS = 8,
  localparam int SLOT_W = $clog2(NUM_SLOTS)
) (
  input  logic clk,
  input  logic rst,
  input  logic [NUM_SLOTS-1:0] hits,
  output logic pulse,
  output logic [SLOT_W-1:0] slot
);
  logic any;
  logic [SLOT_W-1:0] sel;

  always_comb begin
    any = 1'b0;
    sel = '0;
    for (int i = NUM_SLOTS - 1; i >= 0; i--) begin
      if (hits[i]) begin
        any = 1'b1;
        sel = SLOT_W'(i);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pulse <= 1'b0;
      slot <= '0;
    end else begin
      pulse <= any;
      slot <= any ? sel : '0;
    end
  end

  // R7: the reported slot hit, and no lower slot did
  a_r7_lowest_reported: assert property (@(posedge clk) disable iff (rst)
    pulse |-> ((($past(hits) >> slot) & NUM_SLOTS'(1)) != '0) &&
              (($past(hits) & ((NUM_SLOTS'(1) << slot) - NUM_SLOTS'(1))) == '0));
  // R8: no hit, no pulse
  a_r8_pulse_needs_hit: assert property (@(posedge clk) disable iff (rst)
    pulse |-> $past(hits) != '0);
endmodule

// File: rtl/wkp_matcher.sv
module wkp_matcher #(
  parameter int NUM_SLOTS  = 8,
  parameter int MASK_BYTES = 8,
  parameter int ADDR_W     = $clog2(NUM_SLOTS) + 5,
  parameter int SLOT_W     = $clog2(NUM_SLOTS)
) (
  input  logic clk,
  input  logic rst,
  input  logic cfg_we,
  input  logic [ADDR_W-1:0] cfg_addr,
  input  logic [7:0] cfg_wdata,
  input  logic rx_valid,
  input  logic rx_sof,
  input  logic rx_eof,
  input  logic [7:0] rx_data,
  output logic wake_pulse,
  output logic [SLOT_W-1:0] wake_slot
);
  import wkp_pkg::*;
  localparam int WIN = MASK_BYTES * 8;
  localparam int SPAN = 2 * WIN;
  localparam int OFF_W = $clog2(SPAN + NORM_BASE + 2);
  localparam logic [OFF_W-1:0] OFF_MAX = '1;

  function automatic logic [NUM_SLOTS-1:0] second_bits();
    logic [NUM_SLOTS-1:0] r;
    r = '0;
    for (int s = LONG_FIRST; s < NUM_SLOTS; s++) if (s % 2 == 1) r[s] = 1'b1;
    return r;
  endfunction
  localparam logic [NUM_SLOTS-1:0] SECOND_MASK = second_bits();

  logic [NUM_SLOTS-1:0][WIN-1:0] mask;
  logic [NUM_SLOTS-1:0][15:0] crc_ref;
  logic [NUM_SLOTS-1:0][7:0] last_ref;
  logic long_en;

  wkp_regs #(.NUM_SLOTS(NUM_SLOTS), .MASK_BYTES(MASK_BYTES), .ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .mask_o(mask), .crc_o(crc_ref), .last_o(last_ref), .long_en(long_en)
  );

  logic in_frame, byte_ok, eval;
  logic [OFF_W-1:0] cnt_q, offset;
  assign byte_ok = rx_valid && (rx_sof || in_frame);
  assign eval = byte_ok && rx_eof;
  assign offset = rx_sof ? '0 : cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      in_frame <= 1'b0;
      cnt_q <= '0;
    end else if (byte_ok) begin
      in_frame <= !rx_eof;
      cnt_q <= (offset == OFF_MAX) ? OFF_MAX : offset + OFF_W'(1);
    end
  end

  logic [NUM_SLOTS-1:0] hits;

  for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
    logic wide, active;
    logic [SPAN-1:0] eff_mask;
    if (s >= LONG_FIRST && s % 2 == 0 && s + 1 < NUM_SLOTS) begin : g_first
      assign wide = long_en;
      assign active = 1'b1;
      assign eff_mask = long_en ? {mask[s+1], mask[s]} : {{WIN{1'b0}}, mask[s]};
    end else if (s >= LONG_FIRST && s % 2 == 1) begin : g_second
      assign wide = 1'b0;
      assign active = !long_en;
      assign eff_mask = {{WIN{1'b0}}, mask[s]};
    end else begin : g_plain
      assign wide = 1'b0;
      assign active = 1'b1;
      assign eff_mask = {{WIN{1'b0}}, mask[s]};
    end

    wkp_slot_engine #(.WIN(WIN), .OFF_W(OFF_W)) u_eng (
      .clk(clk), .rst(rst), .byte_ok(byte_ok), .sof(rx_sof), .eval(eval),
      .offset(offset), .data(rx_data), .mask(eff_mask), .wide(wide),
      .active(active), .ref_crc(crc_ref[s]), .ref_last(last_ref[s]), .hit(hits[s])
    );
  end

  wkp_arbiter #(.NUM_SLOTS(NUM_SLOTS)) u_arb (
    .clk(clk), .rst(rst), .hits(hits), .pulse(wake_pulse), .slot(wake_slot)
  );

  // R4: second slots of pairs stay silent in wide mode
  a_r4_second_silent: assert property (@(posedge clk) disable iff (rst)
    long_en |-> ((hits & SECOND_MASK) == '0));
  // R8: pulse only in the cycle after an end-of-frame byte
  a_r8_pulse_after_eof: assert property (@(posedge clk) disable iff (rst)
    wake_pulse |-> $past(rx_valid && rx_eof));
  // R8: slot number is zero whenever no pulse
  a_r8_idle_slot_zero: assert property (@(posedge clk) disable iff (rst)
    !wake_pulse |-> (wake_slot == '0));
endmodule

// File: tb/wkp_matcher_test.sv
module wkp_matcher_test;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cfg_we = 1'b0;
  logic [7:0] cfg_addr = '0;
  logic [7:0] cfg_wdata = '0;
  logic rx_valid = 1'b0, rx_sof = 1'b0, rx_eof = 1'b0;
  logic [7:0] rx_data = '0;
  logic wake_pulse;
  logic [2:0] wake_slot;

  int total = 0;
  int bad = 0;
  logic [7:0] frm [0:159];

  always #10 clk = ~clk;

  wkp_matcher uut (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .rx_valid(rx_valid), .rx_sof(rx_sof), .rx_eof(rx_eof), .rx_data(rx_data),
    .wake_pulse(wake_pulse), .wake_slot(wake_slot)
  );

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [15:0] crc_byte(input logic [15:0] c, input logic [7:0] d);
    logic [15:0] r;
    r = c;
    for (int b = 7; b >= 0; b--) begin
      if (r[15] ^ d[b]) r = (r << 1) ^ 16'h8005;
      else r = r << 1;
    end
    return r;
  endfunction

  task automatic model(input logic [127:0] m, input int base, input int span, input int len,
                       output logic [15:0] c, output logic [7:0] lb);
    c = 16'hFFFF;
    lb = 8'h00;
    for (int i = 0; i < len; i++) begin
      if (i >= base && i - base < span && m[i - base]) begin
        c = crc_byte(c, frm[i]);
        lb = frm[i];
      end
    end
  endtask

  task automatic fill(input int seed);
    for (int i = 0; i < 160; i++) frm[i] = 8'((i * seed) ^ (i >> 2) ^ seed);
  endtask

  task automatic wr(input int addr, input logic [7:0] d);
    @(negedge clk);
    cfg_we = 1'b1;
    cfg_addr = 8'(addr);
    cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic prog(input int s, input logic [63:0] m, input logic [15:0] c, input logic [7:0] lb);
    for (int k = 0; k < 8; k++) wr(s * 16 + k, m[8*k +: 8]);
    wr(s * 16 + 8, c[7:0]);
    wr(s * 16 + 9, c[15:8]);
    wr(s * 16 + 10, lb);
  endtask

  task automatic run_frame(input int len, input bit exp_hit, input int exp_slot, input string req);
    for (int i = 0; i < len; i++) begin
      @(negedge clk);
      rx_valid = 1'b1;
      rx_sof = (i == 0);
      rx_eof = (i == len - 1);
      rx_data = frm[i];
    end
    @(negedge clk);
    rx_valid = 1'b0;
    rx_sof = 1'b0;
    rx_eof = 1'b0;
    check({req, " pulse"}, int'(wake_pulse), int'(exp_hit));
    check({req, " slot"}, int'(wake_slot), exp_hit ? exp_slot : 0);
    @(negedge clk);
    check("R8 pulse width", int'(wake_pulse), 0);
  endtask

  logic [63:0] mn = 64'h0000_0040_0F00_A513;
  logic [15:0] c;
  logic [7:0] lb;

  task automatic t_reset();
    check("R9 reset pulse", int'(wake_pulse), 0);
    check("R9 reset slot", int'(wake_slot), 0);
    fill(5);
    run_frame(90, 1'b0, 0, "R9 empty bank");
  endtask

  task automatic t_normal();
    fill(7);
    model({64'b0, mn}, 12, 64, 80, c, lb);
    prog(0, mn, {8'h5A, c[7:0]}, lb);
    run_frame(80, 1'b1, 0, "R1 normal match");
    prog(0, mn, {8'h5A, c[7:0] ^ 8'h01}, lb);
    run_frame(80, 1'b0, 0, "R1 wrong crc");
    prog(0, mn, {8'h5A, c[7:0]}, lb ^ 8'h80);
    run_frame(80, 1'b0, 0, "R2 wrong last byte");
    prog(0, mn, {8'h5A, c[7:0]}, lb);
    // highest selected offset is 12+38 = 50
    run_frame(50, 1'b0, 0, "R5 short frame");
    model({64'b0, mn}, 12, 64, 51, c, lb);
    prog(0, mn, {8'h00, c[7:0]}, lb);
    run_frame(51, 1'b1, 0, "R5 boundary frame");
    prog(0, 64'b0, {8'h00, c[7:0]}, lb);
    run_frame(51, 1'b0, 0, "R6 zero mask");
  endtask

  task automatic t_priority();
    fill(11);
    model({64'b0, mn}, 12, 64, 70, c, lb);
    prog(5, mn, c, lb);
    prog(3, mn, c, lb);
    prog(1, mn, c, lb);
    run_frame(70, 1'b1, 1, "R7 lowest of 1,3,5");
    prog(1, 64'b0, c, lb);
    run_frame(70, 1'b1, 3, "R7 R6 after clearing 1");
    prog(3, 64'b0, c, lb);
    prog(5, 64'b0, c, lb);
  endtask

  task automatic t_wide();
    logic [63:0] m2 = 64'h0000_F000_0000_00FF;
    logic [63:0] m3 = 64'h0008_0000_0000_0101;
    logic [15:0] c0;
    logic [7:0] lb0;
    fill(13);
    wr(8'h80, 8'h01);
    // wide: highest selected offset 64+51 = 115
    model({m3, m2}, 0, 128, 120, c, lb);
    prog(2, m2, c, lb ^ 8'hFF);
    prog(3, m3, ~c, 8'h3C);
    run_frame(120, 1'b1, 2, "R3 wide match");
    run_frame(115, 1'b0, 0, "R3 R5 wide short");
    prog(2, m2, {c[15:8] ^ 8'h10, c[7:0]}, lb);
    run_frame(120, 1'b0, 0, "R3 high crc byte");
    prog(2, m2, c, lb);
    model({64'b0, mn}, 12, 64, 120, c0, lb0);
    prog(0, mn, {8'h00, c0[7:0]}, lb0);
    run_frame(120, 1'b1, 0, "R4 slot0 normal in wide mode");
    prog(0, 64'b0, 16'h0, 8'h0);
    prog(3, m3, 16'h1234, 8'h77);
    run_frame(120, 1'b1, 2, "R4 second slot fields ignored");
    // second slot alone programmed to match as a normal pattern
    model({64'b0, m3}, 12, 64, 120, c0, lb0);
    prog(2, m2, ~c, lb);
    prog(3, m3, {8'h00, c0[7:0]}, lb0);
    run_frame(120, 1'b0, 0, "R4 second slot silent");
    wr(8'h80, 8'h00);
    run_frame(120, 1'b1, 3, "R4 second slot normal when off");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_normal();
    t_priority();
    t_wide();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(20 * 150000);
    total++;
    bad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule